// File: doc/BRIEF.md
# Multi-Channel Threshold Trigger with Coincidence

This block watches a set of parallel sample streams, one per channel, and decides when an acquisition should be triggered. Each channel compares its incoming sample against its own threshold, on the over side or the under side as chosen by one shared polarity input. A channel produces a local hit once its signal has stayed on the crossing side for a programmed number of consecutive samples. After a hit, the channel stays quiet until its signal returns to the non-crossing side.

Channel hits are combined under an acquisition mask and a coincidence level. The level sets how many other enabled channels must also be past their thresholds at the moment a channel hits. The qualified local trigger is ORed with an enabled external trigger, taken on its rising edge, and with an enabled software strobe. The result is the global trigger pulse. A second mask with the same bit layout chooses which sources drive a trigger-out pulse. On the trigger-out path, channel hits drive the output directly, without the coincidence qualification.

Top module: `thr_trig_top`

## Requirements
- R1: While reset is asserted, `trig_o` and `trig_out_o` are 0 whatever the other inputs do.
- R2: With `under_i` = 0, a sample is past its threshold only when it is strictly greater than the threshold. A channel hits when its signal is past for N consecutive samples (N = its count setting). `trig_o` rises N+1 clock cycles after the first past sample is presented. A non-past sample restarts the count.
- R3: With `under_i` = 1, a sample is past its threshold only when it is strictly less than the threshold. The counting and timing are the same as in R2.
- R4: A count setting of 0 behaves as a count of 1.
- R5: After a hit, a channel does not hit again until it has seen at least one non-past sample.
- R6: Bits [NCH-1:0] of `acq_mask_i` enable the channels, with bit i for channel i. A hit on a disabled channel never produces `trig_o`, and `trig_o` never rises without an enabled source.
- R7: The coincidence level is `acq_mask_i[26:24]`. A hitting enabled channel yields a local trigger only if at least that many other enabled channels are past their thresholds in the same sample.
- R8: A coincidence level equal to or above the number of enabled channels never yields a local trigger.
- R9: With `acq_mask_i[30]` = 1, a rising edge on `ext_trig_i` raises `trig_o` in the next cycle. Holding `ext_trig_i` high gives no further pulse. With the bit at 0, the external input is ignored.
- R10: With `acq_mask_i[31]` = 1, a cycle with `sw_trig_i` = 1 raises `trig_o` in the next cycle. With the bit at 0, the strobe is ignored.
- R11: `out_mask_i` uses the same layout as the acquisition mask (channels in [NCH-1:0], external in bit 30, software in bit 31). It drives `trig_out_o` with the same timing as `trig_o`, but channel hits are not qualified by the coincidence level.
- R12: `trig_o` and `trig_out_o` are each never high in two consecutive cycles. A request in the cycle right after a pulse is absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per channel per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_i | input | NCH*SW | Samples, channel i at [i*SW +: SW] |
| thr_i | input | NCH*SW | Thresholds, channel i at [i*SW +: SW] |
| len_i | input | NCH*CW | Consecutive-sample counts, channel i at [i*CW +: CW] |
| under_i | input | 1 | Polarity: 0 = over threshold, 1 = under threshold |
| acq_mask_i | input | 32 | Acquisition source mask and coincidence level |
| out_mask_i | input | 32 | Trigger-out source mask |
| ext_trig_i | input | 1 | External trigger level |
| sw_trig_i | input | 1 | Software trigger strobe, one cycle |
| trig_o | output | 1 | Global acquisition trigger pulse |
| trig_out_o | output | 1 | Trigger-out pulse |

## Verification
The bench builds the block with its defaults: eight channels, 12-bit samples and 12-bit counts. This gives enough channels to show that the coincidence level counts only the other enabled channels, with three channels meeting a level of two and two channels failing it. Counts are kept to small values so that the exact hit cycle, the strict comparison at equality, the restart on a broken run and the re-arm rule can each be checked cycle by cycle. Separate cases cover the zero-count case, both polarities and the pulse that is absorbed right after another.

// File: rtl/thr_trig_pkg.sv
// Package: shared constants for the threshold trigger.
// Fixes the bit positions of the fields inside the 32-bit source masks
// and the polarity encoding. Assumes channel count stays below 24.
package thr_trig_pkg;

    localparam int MASK_W  = 32;
    localparam int EXT_POS = 30;
    localparam int SW_POS  = 31;
    localparam int LVL_LSB = 24;
    localparam int LVL_W   = 3;

    typedef enum logic {
        POL_OVER  = 1'b0,
        POL_UNDER = 1'b1
    } pol_e;

endpackage

// File: rtl/thr_chan.sv
// Module: per-channel time-over-threshold qualifier.
// Compares each sample with the threshold on the side picked by under_i and
// counts consecutive past samples. Fires a one-cycle pulse, registered, in
// the cycle after the count reaches len_i (0 acts as 1). Disarms on a hit
// and re-arms on the first non-past sample. past_o is the registered past
// flag, aligned with fire_o, for coincidence use.
// Assumes settings are held steady while a run is in progress.
module thr_chan
    import thr_trig_pkg::*;
#(
    parameter int SW = 12,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] smp_i,
    input  logic [SW-1:0] thr_i,
    input  logic [CW-1:0] len_i,
    input  logic          under_i,
    output logic          fire_o,
    output logic          past_o
);

    localparam logic [CW:0] ONE = {{CW{1'b0}}, 1'b1};

    logic          past;
    logic [CW-1:0] run_q;
    logic          armed_q;
    logic [CW:0]   need;
    logic [CW:0]   seen;
    logic          hit;

    // Decide whether the current sample lies past the threshold.
    always_comb begin
        if (pol_e'(under_i) == POL_UNDER) past = (smp_i < thr_i);
        else                              past = (smp_i > thr_i);
    end

    // Compare run length including this sample against the required count.
    always_comb begin
        need = (len_i == '0) ? ONE : {1'b0, len_i};
        seen = {1'b0, run_q} + ONE;
        hit  = past && armed_q && (seen == need);
    end

    // Count consecutive past samples, saturating, cleared by a non-past one.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (!past)      run_q <= '0;
        else if (run_q != '1) run_q <= run_q + 1'b1;
    end

    // Disarm on a hit, re-arm once the signal leaves the crossing side.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed_q <= 1'b1;
        else if (hit)   armed_q <= 1'b0;
        else if (!past) armed_q <= 1'b1;
    end

    // Register the hit pulse and the past flag together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_o <= 1'b0;
            past_o <= 1'b0;
        end else begin
            fire_o <= hit;
            past_o <= past;
        end
    end

endmodule

// File: rtl/thr_coinc.sv
// Module: coincidence qualifier for channel hits.
// A hit on enabled channel i counts only if the number of other enabled
// channels that are past threshold in the same sample is at least level_i.
// Purely combinational; inputs are the aligned registered channel flags.
module thr_coinc #(
    parameter int NCH = 8,
    parameter int LW  = 3
) (
    input  logic [NCH-1:0] fire_i,
    input  logic [NCH-1:0] past_i,
    input  logic [NCH-1:0] en_i,
    input  logic [LW-1:0]  level_i,
    output logic           hit_o
);

    logic [NCH-1:0] qual;

    for (genvar i = 0; i < NCH; i++) begin : g_qual
        logic [NCH-1:0] others;
        // Other enabled channels past threshold, excluding channel i.
        assign others  = past_i & en_i & ~(NCH'(1) << i);
        // Channel i qualifies when enough others agree.
        assign qual[i] = fire_i[i] && en_i[i]
                         && (int'($countones(others)) >= int'(level_i));
    end

    // Any qualified channel forms the local trigger.
    assign hit_o = |qual;

endmodule

// File: rtl/thr_emit.sv
// Module: source merge and pulse shaper.
// ORs the channel request with the enabled external edge and enabled
// software strobe, then registers it. A request in the cycle right after a
// pulse is absorbed, so the output is never high two cycles in a row.
module thr_emit (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_i,
    input  logic ext_en_i,
    input  logic ext_rise_i,
    input  logic sw_en_i,
    input  logic sw_i,
    output logic pulse_o
);

    logic req;

    // Merge the three sources under their enables.
    always_comb req = chan_i || (ext_en_i && ext_rise_i) || (sw_en_i && sw_i);

    // Register the merged request, blocking back-to-back pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_o <= 1'b0;
        else        pulse_o <= req && !pulse_o;
    end

endmodule

// File: rtl/thr_trig_top.sv
// Module: multi-channel threshold trigger with coincidence (top).
// Instantiates one qualifier per channel, a coincidence stage for the
// acquisition path, and two shapers for the trigger and trigger-out pulses.
// Assumes NCH < 24 so channel bits stay below the level field, and a
// software strobe lasting one cycle.
module thr_trig_top
    import thr_trig_pkg::*;
#(
    parameter int NCH = 8,
    parameter int SW  = 12,
    parameter int CW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*SW-1:0] smp_i,
    input  logic [NCH*SW-1:0] thr_i,
    input  logic [NCH*CW-1:0] len_i,
    input  logic              under_i,
    input  logic [31:0]       acq_mask_i,
    input  logic [31:0]       out_mask_i,
    input  logic              ext_trig_i,
    input  logic              sw_trig_i,
    output logic              trig_o,
    output logic              trig_out_o
);

    logic [NCH-1:0]   fire;
    logic [NCH-1:0]   past;
    logic             ext_q;
    logic             ext_rise;
    logic             local_hit;
    logic             out_chan;
    logic [LVL_W-1:0] level;
    logic             mask_unused;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        thr_chan #(.SW(SW), .CW(CW)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_i   (smp_i[c*SW +: SW]),
            .thr_i   (thr_i[c*SW +: SW]),
            .len_i   (len_i[c*CW +: CW]),
            .under_i (under_i),
            .fire_o  (fire[c]),
            .past_o  (past[c])
        );
    end

    // Remember the previous external level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_trig_i;
    end

    // Decode edge, level field and the direct channel path for trigger-out.
    always_comb begin
        ext_rise    = ext_trig_i && !ext_q;
        level       = acq_mask_i[LVL_LSB +: LVL_W];
        out_chan    = |(fire & out_mask_i[NCH-1:0]);
        mask_unused = ^{acq_mask_i, out_mask_i};
    end

    thr_coinc #(.NCH(NCH), .LW(LVL_W)) coinc_i (
        .fire_i  (fire),
        .past_i  (past),
        .en_i    (acq_mask_i[NCH-1:0]),
        .level_i (level),
        .hit_o   (local_hit)
    );

    thr_emit acq_emit_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_i     (local_hit),
        .ext_en_i   (acq_mask_i[EXT_POS]),
        .ext_rise_i (ext_rise),
        .sw_en_i    (acq_mask_i[SW_POS]),
        .sw_i       (sw_trig_i),
        .pulse_o    (trig_o)
    );

    thr_emit out_emit_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_i     (out_chan),
        .ext_en_i   (out_mask_i[EXT_POS]),
        .ext_rise_i (ext_rise),
        .sw_en_i    (out_mask_i[SW_POS]),
        .sw_i       (sw_trig_i),
        .pulse_o    (trig_out_o)
    );

endmodule

// File: rtl/thr_trig_chk.sv
// Module: property checker for thr_trig_top, attached by bind.
// Observes only ports of the top module.
module thr_trig_chk #(
    parameter int NCH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] acq_mask_i,
    input logic [31:0] out_mask_i,
    input logic        ext_trig_i,
    input logic        sw_trig_i,
    input logic        trig_o,
    input logic        trig_out_o
);

    logic chk_unused;
    assign chk_unused = ^{acq_mask_i, out_mask_i};

    // R12
    trig_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R12
    out_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out_o |=> !trig_out_o);

    // R10
    sw_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_trig_i && acq_mask_i[31] && !trig_o) |=> trig_o);

    // R9
    ext_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ext_trig_i) && acq_mask_i[30] && !trig_o) |=> trig_o);

    // R11
    out_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_trig_i && out_mask_i[31] && !trig_out_o) |=> trig_out_o);

    // R6
    trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past((sw_trig_i && acq_mask_i[31])
                         || (ext_trig_i && acq_mask_i[30])
                         || (|acq_mask_i[NCH-1:0])));

endmodule

bind thr_trig_top thr_trig_chk #(.NCH(NCH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_mask_i (acq_mask_i),
    .out_mask_i (out_mask_i),
    .ext_trig_i (ext_trig_i),
    .sw_trig_i  (sw_trig_i),
    .trig_o     (trig_o),
    .trig_out_o (trig_out_o)
);

// File: tb/thr_trig_tb.sv
`timescale 1ns/1ps
// Bench: table-driven stream on channel 0, then directed cases.
// Inputs change at the falling edge; outputs are read at the next falling
// edge, after the rising edge that consumed the inputs.
module thr_trig_top_tb_top;

    localparam int NCH = 8;
    localparam int SW  = 12;
    localparam int CW  = 12;
    localparam int NROW = 15;

    // Channel 0 samples, threshold 100, count 3, over mode.
    localparam int TBL_S [NROW] = '{50, 150, 150, 150, 150, 150, 100, 101,
                                    101, 50, 200, 200, 200, 50, 50};
    localparam bit TBL_E [NROW] = '{0, 0, 0, 0, 1, 0, 0, 0,
                                    0, 0, 0, 0, 0, 1, 0};

    logic clk = 1'b0;
    logic rst_n;
    logic [SW-1:0] smp [NCH];
    logic [SW-1:0] thr [NCH];
    logic [CW-1:0] len [NCH];
    logic [NCH*SW-1:0] smp_bus;
    logic [NCH*SW-1:0] thr_bus;
    logic [NCH*CW-1:0] len_bus;
    logic under;
    logic [31:0] acq_mask;
    logic [31:0] out_mask;
    logic ext_trig;
    logic sw_trig;
    logic trig;
    logic trig_out;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            smp_bus[c*SW +: SW] = smp[c];
            thr_bus[c*SW +: SW] = thr[c];
            len_bus[c*CW +: CW] = len[c];
        end
    end

    thr_trig_top #(.NCH(NCH), .SW(SW), .CW(CW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_i      (smp_bus),
        .thr_i      (thr_bus),
        .len_i      (len_bus),
        .under_i    (under),
        .acq_mask_i (acq_mask),
        .out_mask_i (out_mask),
        .ext_trig_i (ext_trig),
        .sw_trig_i  (sw_trig),
        .trig_o     (trig),
        .trig_out_o (trig_out)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b exp %0b", tag, got, exp);
        end
    endtask

    task automatic all_smp(input int v);
        for (int c = 0; c < NCH; c++) smp[c] = SW'(v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog got timeout exp finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        under    = 1'b0;
        ext_trig = 1'b0;
        sw_trig  = 1'b1;
        acq_mask = 32'h8000_0000;
        out_mask = 32'h8000_0000;
        for (int c = 0; c < NCH; c++) begin
            smp[c] = '0;
            thr[c] = 12'd100;
            len[c] = 12'd1;
        end
        @(negedge clk);
        repeat (3) cyc();
        chk(trig, 1'b0, "R1 trig in reset");
        chk(trig_out, 1'b0, "R1 trig_out in reset");
        sw_trig  = 1'b0;
        acq_mask = 32'h0000_0001;
        out_mask = 32'h0000_0001;
        len[0]   = 12'd3;
        cyc();
        rst_n = 1'b1;
        cyc();

        // R2 R5 table: strict compare, count of 3, restart, re-arm
        for (int r = 0; r < NROW; r++) begin
            smp[0] = SW'(TBL_S[r]);
            cyc();
            chk(trig, TBL_E[r], $sformatf("R2 R5 row %0d trig", r));
            chk(trig_out, TBL_E[r], $sformatf("R2 row %0d trig_out", r));
        end

        // R3 under polarity
        acq_mask = '0;
        out_mask = '0;
        all_smp(500);
        cyc();
        under = 1'b1;
        cyc();
        cyc();
        acq_mask = 32'h0000_0001;
        out_mask = 32'h0000_0001;
        len[0]   = 12'd1;
        smp[0]   = 12'd50;
        cyc();
        chk(trig, 1'b0, "R3 under before");
        cyc();
        chk(trig, 1'b1, "R3 under fire");
        cyc();
        chk(trig, 1'b0, "R3 R5 no refire while past");

        // R4 zero count acts as one
        smp[0] = 12'd500;
        cyc();
        len[0] = 12'd0;
        smp[0] = 12'd50;
        cyc();
        chk(trig, 1'b0, "R4 before");
        cyc();
        chk(trig, 1'b1, "R4 zero count");
        cyc();

        // back to over mode
        acq_mask = '0;
        out_mask = '0;
        all_smp(0);
        under = 1'b0;
        for (int c = 0; c < NCH; c++) len[c] = 12'd2;
        cyc();
        cyc();

        // R6 R11 disabled for acquisition, enabled for trigger-out
        out_mask = 32'h0000_0004;
        smp[2] = 12'd300;
        cyc();
        cyc();
        chk(trig_out, 1'b0, "R11 before");
        cyc();
        chk(trig_out, 1'b1, "R11 channel on trig_out");
        chk(trig, 1'b0, "R6 disabled channel");
        smp[2] = '0;
        out_mask = '0;
        cyc();

        // R7 level 1, one channel alone
        acq_mask = 32'h0100_0003;
        out_mask = 32'h0000_0001;
        smp[0] = 12'd300;
        for (int k = 0; k < 4; k++) begin
            cyc();
            chk(trig, 1'b0, "R7 lone channel");
        end
        chk(trig_out, 1'b0, "R11 settled");
        out_mask = '0;
        smp[0] = '0;
        cyc();

        // R7 level 1, two channels together
        smp[0] = 12'd300;
        smp[1] = 12'd300;
        cyc();
        cyc();
        chk(trig, 1'b0, "R7 pair before");
        cyc();
        chk(trig, 1'b1, "R7 pair coincidence");
        all_smp(0);
        cyc();

        // R8 level 2 with two enabled channels
        acq_mask = 32'h0200_0003;
        smp[0] = 12'd300;
        smp[1] = 12'd300;
        for (int k = 0; k < 4; k++) begin
            cyc();
            chk(trig, 1'b0, "R8 level not below enabled");
        end
        all_smp(0);
        cyc();

        // R7 level 2 with three channels
        acq_mask = 32'h0200_0007;
        smp[0] = 12'd300;
        smp[1] = 12'd300;
        smp[2] = 12'd300;
        cyc();
        cyc();
        chk(trig, 1'b0, "R7 triple before");
        cyc();
        chk(trig, 1'b1, "R7 triple coincidence");
        all_smp(0);
        cyc();
        cyc();

        // R9 external edge enabled
        acq_mask = 32'h4000_0000;
        out_mask = 32'h4000_0000;
        ext_trig = 1'b1;
        cyc();
        chk(trig, 1'b1, "R9 ext edge");
        chk(trig_out, 1'b1, "R11 ext edge");
        cyc();
        chk(trig, 1'b0, "R9 ext held");
        cyc();
        chk(trig, 1'b0, "R9 ext held later");
        ext_trig = 1'b0;
        cyc();
        // R9 external disabled
        acq_mask = '0;
        out_mask = '0;
        ext_trig = 1'b1;
        cyc();
        chk(trig, 1'b0, "R9 ext disabled");
        ext_trig = 1'b0;
        cyc();

        // R10 software strobe
        acq_mask = 32'h8000_0000;
        sw_trig = 1'b1;
        cyc();
        sw_trig = 1'b0;
        chk(trig, 1'b1, "R10 sw enabled");
        cyc();
        chk(trig, 1'b0, "R10 sw single");
        acq_mask = '0;
        sw_trig = 1'b1;
        cyc();
        sw_trig = 1'b0;
        chk(trig, 1'b0, "R10 sw disabled");
        cyc();

        // R11 software on trigger-out only
        out_mask = 32'h8000_0000;
        sw_trig = 1'b1;
        cyc();
        sw_trig = 1'b0;
        chk(trig_out, 1'b1, "R11 sw trig_out");
        chk(trig, 1'b0, "R11 sw not on trig");
        out_mask = '0;
        cyc();

        // R12 back-to-back requests
        acq_mask = 32'hC000_0000;
        ext_trig = 1'b1;
        cyc();
        chk(trig, 1'b1, "R12 first pulse");
        sw_trig = 1'b1;
        cyc();
        sw_trig = 1'b0;
        chk(trig, 1'b0, "R12 absorbed pulse");
        ext_trig = 1'b0;
        cyc();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule